// File: doc/BRIEF.md
# Occupancy-Based Adaptive Column Selector

This block picks the tile column that an adaptively routed packet should head for inside a tiled high-radix switch. Route computation hands it a mask of every output port the packet may legally use. The block folds that port mask down to one candidate bit per column and then picks the candidate column whose input buffers look least busy. It finishes by breaking any remaining tie with a rotating priority, so that equally loaded columns take turns.

Each column reports a small occupancy code. Selection has two stages. A coarse stage looks only at the top bit of each code and keeps the candidates whose top bit is clear, if there are any. A fine stage compares the two bits just below the top bit among the remaining candidates and keeps those with the smallest value. A round-robin pointer then picks one survivor. The result is registered and appears on the clock edge that samples the request strobe.

Top module: `adaptive_col_sel`

## Requirements
- R1: Feasible port p maps to column p mod NUM_COLS; a column is a candidate when any of its feasible ports is set, and only a candidate column is ever granted.
- R2: When at least one candidate has occupancy bit OCC_W-1 equal to 0, no candidate with that bit equal to 1 is granted.
- R3: Among the candidates kept by R2, only those with the smallest value of occupancy bits [OCC_W-2 -: 2] (bits [1:0] at the default width) can be granted.
- R4: Ties left after R3 go to the first tied column found by searching upward from the round-robin pointer, wrapping from NUM_COLS-1 to 0.
- R5: After a grant to column k, the pointer becomes (k+1) mod NUM_COLS. A cycle with no grant leaves the pointer unchanged, and that includes a cycle with the strobe low.
- R6: A strobe with an all-zero candidate mask gives grant_valid_o low and grant_o all zero, and the pointer does not move.
- R7: grant_o and grant_valid_o are registered and change on the clock edge that samples req_i high. The strobe being low at an edge drives both to zero. grant_o is one-hot whenever grant_valid_o is high.
- R8: Synchronous active-high reset clears grant_o and grant_valid_o and returns the pointer to column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Selection request strobe |
| port_mask_i | input | NUM_PORTS | Feasible output ports; bit p belongs to column p mod NUM_COLS |
| occ_i | input | NUM_COLS*OCC_W | Occupancy code of column c at bits [c*OCC_W +: OCC_W] |
| grant_o | output | NUM_COLS | One-hot chosen column |
| grant_valid_o | output | 1 | A column was granted |

## Verification
The selection path is tried with several kinds of input. A single feasible port shows the port-to-column fold. A mix of top-bit-set and top-bit-clear candidates shows that the coarse stage is applied before the fine stage. The bench also uses a low-occupancy column that has a poor fine value, a lone candidate that has a high occupancy, and a full mask with equal occupancy everywhere; between them these separate the coarse filter, the fine compare and candidate gating from each other. Repeated tied patterns, together with an empty mask, an idle strobe and a reset mid-run, each followed by an all-tied probe, show where the rotating pointer stands and whether it wraps, advances or holds.

// File: rtl/colsel_pkg.sv
package colsel_pkg;

    localparam int DEF_PORTS = 64;
    localparam int DEF_COLS  = 8;
    localparam int DEF_OCC_W = 3;
    localparam int FINE_W    = 2;

    typedef enum logic {
        TIER_COOL = 1'b0,
        TIER_ALL  = 1'b1
    } tier_e;

    function automatic int wrap_next(input int v, input int n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/colsel_fold.sv
module colsel_fold #(
    parameter int NUM_PORTS = colsel_pkg::DEF_PORTS,
    parameter int NUM_COLS  = colsel_pkg::DEF_COLS
) (
    input  logic [NUM_PORTS-1:0] port_mask,
    output logic [NUM_COLS-1:0]  cand
);
    localparam int ROWS = (NUM_PORTS + NUM_COLS - 1) / NUM_COLS;

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        logic [ROWS-1:0] members;
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            if (r * NUM_COLS + c < NUM_PORTS) begin : g_live
                assign members[r] = port_mask[r * NUM_COLS + c];
            end else begin : g_pad
                assign members[r] = 1'b0;
            end
        end
        assign cand[c] = |members;
    end
endmodule

// File: rtl/colsel_occ_filter.sv
module colsel_occ_filter
    import colsel_pkg::*;
#(
    parameter int NUM_COLS = DEF_COLS,
    parameter int OCC_W    = DEF_OCC_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_COLS-1:0]       cand,
    input  logic [NUM_COLS*OCC_W-1:0] occ,
    output logic [NUM_COLS-1:0]       best
);
    localparam int FINE_LSB = OCC_W - 1 - FINE_W;

    logic [NUM_COLS-1:0] cool;
    logic [NUM_COLS-1:0] tier_set;
    logic [FINE_W-1:0]   fine [NUM_COLS];
    logic [FINE_W-1:0]   min_fine;
    tier_e               tier;

    always_comb begin
        for (int c = 0; c < NUM_COLS; c++) begin
            cool[c] = cand[c] & ~occ[c*OCC_W + OCC_W - 1];
            fine[c] = occ[c*OCC_W + FINE_LSB +: FINE_W];
        end
        tier     = (|cool) ? TIER_COOL : TIER_ALL;
        tier_set = (tier == TIER_COOL) ? cool : cand;
    end

    always_comb begin
        min_fine = '1;
        for (int c = 0; c < NUM_COLS; c++) begin
            if (tier_set[c] && (fine[c] < min_fine)) min_fine = fine[c];
        end
        for (int c = 0; c < NUM_COLS; c++) begin
            best[c] = tier_set[c] && (fine[c] == min_fine);
        end
    end

    // R2: a cool candidate shuts out every hot one
    assert_cool_first_R2: assert property (@(posedge clk) disable iff (rst)
        (|cool) |-> ((best & ~cool) == '0));

    // R3: survivors are candidates, and some survive whenever a candidate exists
    assert_best_subset_R3: assert property (@(posedge clk) disable iff (rst)
        ((best & ~cand) == '0) && ((|cand) == (|best)));
endmodule

// File: rtl/colsel_rr_pick.sv
module colsel_rr_pick
    import colsel_pkg::*;
#(
    parameter int NUM_COLS = DEF_COLS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        advance,
    input  logic [NUM_COLS-1:0]         best,
    output logic [NUM_COLS-1:0]         pick,
    output logic                        found
);
    localparam int IDX_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;

    logic [IDX_W-1:0] ptr;
    logic [IDX_W-1:0] idx;

    always_comb begin
        int j;
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < NUM_COLS; i++) begin
            j = int'(ptr) + i;
            if (j >= NUM_COLS) j = j - NUM_COLS;
            if (!found && best[j]) begin
                found = 1'b1;
                idx   = IDX_W'(j);
            end
        end
        pick = found ? (NUM_COLS'(1) << idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (advance && found) begin
            ptr <= IDX_W'(wrap_next(int'(idx), NUM_COLS));
        end
    end

    // R5: pointer holds when nothing is granted
    assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(advance && found) |=> $stable(ptr));

    // R4: the chosen column is one of the tied survivors
    assert_pick_in_best_R4: assert property (@(posedge clk) disable iff (rst)
        found |-> ($onehot(pick) && ((pick & best) != '0)));
endmodule

// File: rtl/adaptive_col_sel.sv
module adaptive_col_sel
    import colsel_pkg::*;
#(
    parameter int NUM_PORTS = DEF_PORTS,
    parameter int NUM_COLS  = DEF_COLS,
    parameter int OCC_W     = DEF_OCC_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_i,
    input  logic [NUM_PORTS-1:0]      port_mask_i,
    input  logic [NUM_COLS*OCC_W-1:0] occ_i,
    output logic [NUM_COLS-1:0]       grant_o,
    output logic                      grant_valid_o
);
    logic [NUM_COLS-1:0] cand;
    logic [NUM_COLS-1:0] best;
    logic [NUM_COLS-1:0] pick;
    logic                found;

    colsel_fold #(.NUM_PORTS(NUM_PORTS), .NUM_COLS(NUM_COLS)) u_fold (
        .port_mask (port_mask_i),
        .cand      (cand)
    );

    colsel_occ_filter #(.NUM_COLS(NUM_COLS), .OCC_W(OCC_W)) u_filter (
        .clk  (clk),
        .rst  (rst),
        .cand (cand),
        .occ  (occ_i),
        .best (best)
    );

    colsel_rr_pick #(.NUM_COLS(NUM_COLS)) u_rr (
        .clk     (clk),
        .rst     (rst),
        .advance (req_i),
        .best    (best),
        .pick    (pick),
        .found   (found)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_o       <= '0;
            grant_valid_o <= 1'b0;
        end else begin
            grant_o       <= req_i ? pick : '0;
            grant_valid_o <= req_i && found;
        end
    end

    // R7: grant shape follows the valid flag
    assert_grant_shape_R7: assert property (@(posedge clk) disable iff (rst)
        grant_valid_o ? $onehot(grant_o) : (grant_o == '0));

    // R7: a grant only follows a sampled strobe
    assert_grant_latency_R7: assert property (@(posedge clk) disable iff (rst)
        grant_valid_o |-> $past(req_i));

    // R1: the granted column was a candidate when the strobe was sampled
    assert_grant_is_cand_R1: assert property (@(posedge clk) disable iff (rst)
        grant_valid_o |-> ((grant_o & $past(cand)) != '0));

    // R6: an empty candidate set yields no grant
    assert_empty_no_grant_R6: assert property (@(posedge clk) disable iff (rst)
        (cand == '0) |=> !grant_valid_o);
endmodule

// File: tb/tb_adaptive_col_sel.sv
`timescale 1ns/1ps
module tb_adaptive_col_sel;
    localparam int NUM_PORTS = 64;
    localparam int NUM_COLS  = 8;
    localparam int OCC_W     = 3;
    localparam int N_VEC     = 11;
    localparam int WATCHDOG_CYC = 5000;

    // entry: mask[91:28] occ[27:4] exp_valid[3] exp_col[2:0]
    localparam logic [91:0] VECS [N_VEC] = '{
        {64'h0000_0000_0000_0001, 24'o00000000, 1'b1, 3'd0}, // R1 single port -> col0
        {64'h0000_0000_0000_0600, 24'o00000340, 1'b1, 3'd2}, // R2 cool col2 over hot col1
        {64'hFFFF_FFFF_FFFF_FFFF, 24'o47361415, 1'b1, 3'd3}, // R3 R4 tie 1/3, ptr 3
        {64'hFFFF_FFFF_FFFF_FFFF, 24'o47361415, 1'b1, 3'd1}, // R4 wrap, ptr 4
        {64'hFFFF_FFFF_FFFF_FFFF, 24'o47361415, 1'b1, 3'd3}, // R5 ptr 2
        {64'hFFFF_FFFF_FFFF_FFFF, 24'o76544567, 1'b1, 3'd4}, // R3 all hot, tie 3/4, ptr 4
        {64'h0000_0000_0000_0000, 24'o11111111, 1'b0, 3'd0}, // R6 empty mask
        {64'h8000_0000_0000_0000, 24'o70000000, 1'b1, 3'd7}, // R1 lone hot candidate col7
        {64'hFFFF_FFFF_FFFF_FFFF, 24'o00000000, 1'b1, 3'd0}, // R5 pointer wrapped to 0
        {64'h0000_0000_0080_8010, 24'o20020000, 1'b1, 3'd4}, // R1 R4 cols 4,7 tie, ptr 1
        {64'h0000_0000_0000_0003, 24'o00000043, 1'b1, 3'd0}  // R2 cool beats better fine
    };

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic                      req_i = 1'b0;
    logic [NUM_PORTS-1:0]      port_mask_i = '0;
    logic [NUM_COLS*OCC_W-1:0] occ_i = '0;
    logic [NUM_COLS-1:0]       grant_o;
    logic                      grant_valid_o;

    int n_checks = 0;
    int n_fails  = 0;
    string tags [N_VEC];

    always #2.5 clk = ~clk;

    adaptive_col_sel #(.NUM_PORTS(NUM_PORTS), .NUM_COLS(NUM_COLS), .OCC_W(OCC_W)) dut (
        .clk           (clk),
        .rst           (rst),
        .req_i         (req_i),
        .port_mask_i   (port_mask_i),
        .occ_i         (occ_i),
        .grant_o       (grant_o),
        .grant_valid_o (grant_valid_o)
    );

    task automatic check(input string req, input logic [NUM_COLS-1:0] g_exp,
                         input logic v_exp);
        n_checks++;
        if (grant_o !== g_exp || grant_valid_o !== v_exp) begin
            n_fails++;
            $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
                     req, grant_o, grant_valid_o, g_exp, v_exp);
        end
    endtask

    // drive at a falling edge, check after the next rising edge, then drop req
    task automatic apply(input logic [63:0] mask, input logic [23:0] occ,
                         input logic v_exp, input logic [2:0] col, input string req);
        logic [NUM_COLS-1:0] g_exp;
        g_exp = v_exp ? (NUM_COLS'(1) << col) : '0;
        port_mask_i = mask;
        occ_i       = occ;
        req_i       = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(req, g_exp, v_exp);
        req_i = 1'b0;
    endtask

    task automatic idle_check(input string req);
        @(posedge clk);
        @(negedge clk);
        check(req, '0, 1'b0);
    endtask

    initial begin
        #(WATCHDOG_CYC * 5.0);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        tags[0] = "R1"; tags[1] = "R2"; tags[2] = "R3/R4"; tags[3] = "R4";
        tags[4] = "R5"; tags[5] = "R3"; tags[6] = "R6";    tags[7] = "R1";
        tags[8] = "R5"; tags[9] = "R4"; tags[10] = "R2";

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset state", '0, 1'b0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < N_VEC; i++) begin
            apply(VECS[i][91:28], VECS[i][27:4], VECS[i][3], VECS[i][2:0], tags[i]);
        end
        // pointer now at 1

        // R7: strobe low gives no grant even with candidates present
        port_mask_i = '1;
        occ_i       = '0;
        idle_check("R7 no strobe no grant");
        // R5: idle cycle left pointer at 1
        apply('1, '0, 1'b1, 3'd1, "R5 idle holds pointer");
        // R7: output returns to zero the cycle after the strobe drops
        idle_check("R7 grant clears");

        // R6: empty mask, then pointer still at 2
        apply('0, '0, 1'b0, 3'd0, "R6 empty mask no grant");
        apply('1, '0, 1'b1, 3'd2, "R6 pointer unchanged after empty");

        // R8: reset mid-run returns pointer to 0
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R8 reset clears outputs", '0, 1'b0);
        rst = 1'b0;
        apply('1, '0, 1'b1, 3'd0, "R8 pointer back at 0");

        // R1: port 13 lands in column 5
        apply(64'h0000_0000_0000_2000, '0, 1'b1, 3'd5, "R1 port 13 -> col5");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule